// File: doc/BRIEF.md
# Transmit FIFO Interval Pacer with Transmit History

This block decides when a transmit queue may hand its next frame to the CAN transmit scheduler. It watches four things: the queue enable, the queue empty flag, a programmable gap length, and a pulse from the protocol core for each frame that went out. From these it produces a single registered permission, `req_next`. When the queue is switched on, the first frame is allowed out at once. After each transmitted frame, a gap counter is loaded. It counts down on an external prescaler tick, and the next frame is held back until the gap has fully elapsed.

The gap counter does not care whether the queue drains during the gap. A frame written while the gap is still running waits for the rest of the gap. If the gap ends while the queue is empty, pacing is idle, and the next frame written is allowed out with no wait. A gap length of zero turns pacing off entirely. Switching the queue off clears the gap and withdraws the permission.

Beside the pacer sits a small history queue, 16 entries deep by default. It logs the identifier and the software tag of every frame reported as transmitted. Host software pops entries one at a time, and each read returns its data one cycle after the request. When the history is full, a new entry is thrown away and a sticky overflow flag is raised. A host write clears the flag.

Top module: `txq_pacer`

## Requirements
- R1: After reset, `req_next` is 0, `hist_vld` is 0, `hist_empty` is 1, `hist_level` is 0 and `hist_ovf` is 0.
- R2: With the gap idle, `fifo_en`=1 and `fifo_empty`=0 in a cycle make `req_next` 1 after the next clock edge. There is no wait after enabling.
- R3: A `tx_done` pulse with `fifo_en`=1 and `gap_interval`=N>0 drops `req_next` after that edge. `req_next` returns on the edge that samples the N-th `gap_tick` after the pulse. Cycles without a tick do not advance the gap.
- R4: If `fifo_empty` goes high during a gap, the gap keeps counting. A frame that arrives before the gap ends is not granted until the N-th tick.
- R5: If the gap runs out while `fifo_empty`=1, then `req_next` rises on the edge after `fifo_empty` first returns to 0, however long the queue stayed empty.
- R6: With `gap_interval`=0, `tx_done` pulses never drop `req_next` while the queue stays enabled and non-empty.
- R7: `fifo_en`=0 drops `req_next` after the next edge and clears any running gap. Enabling again with a non-empty queue grants on the following edge.
- R8: `req_next` is high only after a cycle in which `fifo_en`=1 and `fifo_empty`=0.
- R9: Every `tx_done` pulse, whether the queue is enabled or not, appends {`tx_id`, `tx_tag`} to the history if it is not full. `hist_level` counts the stored entries.
- R10: A `hist_rd` pulse with the history non-empty returns the oldest entry on `hist_id`/`hist_tag`, with `hist_vld`=1 after the next edge. Entries come out in the order they were written.
- R11: A `tx_done` arriving while `hist_level` equals the depth (16) is dropped. `hist_level` stays at 16, and `hist_ovf` becomes 1 and stays 1.
- R12: `hist_ovf_clr` clears `hist_ovf`. If a drop happens in the same cycle as the clear, the flag stays set.
- R13: `hist_rd` on an empty history is ignored: `hist_vld` stays 0 and `hist_level` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Transmit queue enable |
| fifo_empty | input | 1 | Transmit queue holds no frame |
| gap_interval | input | IV_W | Gap length in prescaler ticks (0 = no pacing) |
| gap_tick | input | 1 | Prescaler tick that advances the gap |
| tx_done | input | 1 | One-cycle pulse: a frame was transmitted |
| tx_id | input | ID_W | Identifier of the transmitted frame |
| tx_tag | input | TAG_W | Software reference tag of the transmitted frame |
| req_next | output | 1 | Permission to pass the next frame to the scheduler |
| hist_rd | input | 1 | Host pops one history entry |
| hist_ovf_clr | input | 1 | Host clears the overflow flag |
| hist_vld | output | 1 | Popped entry is on hist_id/hist_tag |
| hist_id | output | ID_W | Identifier of the popped entry |
| hist_tag | output | TAG_W | Tag of the popped entry |
| hist_level | output | $clog2(DEPTH)+1 | Number of stored history entries |
| hist_empty | output | 1 | History holds no entry |
| hist_ovf | output | 1 | Sticky overflow flag |

## Verification
The pacer is swept over every gap length from 1 to 15, with the tick arriving every few cycles. This measures the exact grant edge and shows that idle cycles between ticks do not shorten the gap. A second pattern empties the queue mid-gap and refills it before expiry; this separates "gap keeps running" from "gap restarts" and from "empty aborts the gap". A third pattern lets the gap expire on an empty queue and refills it much later; this separates an immediate grant from a fresh gap. The history is filled past its depth with computed identifiers and tags, then drained, to confirm ordering, dropping, and overflow set and clear priority.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Combined push/pop action on the history queue in one cycle.
  typedef enum logic [1:0] {
    H_IDLE = 2'b00,
    H_PUSH = 2'b01,
    H_POP  = 2'b10,
    H_BOTH = 2'b11
  } hist_op_e;

  // Next value of the gap down-counter.
  // Priority: disable clears, a transmitted frame reloads, a tick decrements.
  function automatic int unsigned gap_step(
    input int unsigned cur,
    input int unsigned load,
    input logic        en,
    input logic        done,
    input logic        tick
  );
    if (!en)                  return 0;
    if (done)                 return load;
    if (tick && (cur != 0))   return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/txq_gap_timer.sv
module txq_gap_timer #(
  parameter int IV_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_en,
  input  logic            fifo_empty,
  input  logic [IV_W-1:0] interval,
  input  logic            tick,
  input  logic            tx_done,
  output logic            req_q
);

  logic [IV_W-1:0] cnt_q;
  logic [IV_W-1:0] cnt_d;
  logic            req_d;

  always_comb begin
    cnt_d = IV_W'(txq_pkg::gap_step(32'(cnt_q), 32'(interval), fifo_en, tx_done, tick));
    // Grant only when no gap will be pending after this edge.
    req_d = fifo_en && !fifo_empty && (cnt_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  // R8: a grant needs an enabled, non-empty queue one cycle earlier
  a_r8_req_needs_ready: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(fifo_en && !fifo_empty));

  // R3: a transmitted frame with a non-zero gap withdraws the grant
  a_r3_gap_blocks: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && tx_done && (interval != '0)) |=> !req_q);

  // R7: disabling withdraws the grant
  a_r7_disable_drops: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !req_q);

  // R6: zero gap keeps a standing grant through transmissions
  a_r6_zero_gap_keeps: assert property (@(posedge clk) disable iff (rst)
    (req_q && fifo_en && !fifo_empty && (interval == '0)) |=> req_q);

endmodule

// File: rtl/txq_hist_fifo.sv
module txq_hist_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 37
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_en,
  input  logic                     ovf_clr,
  output logic                     rd_vld,
  output logic [W-1:0]             rd_data,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     empty,
  output logic                     ovf
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, push, pop;
  txq_pkg::hist_op_e op;

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign op    = txq_pkg::hist_op_e'({pop, push});

  // Storage without reset so that a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      rd_vld <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      rd_vld <= pop;
      if (push) wr_ptr <= (wr_ptr == LAST_IX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_IX) ? '0 : rd_ptr + 1'b1;
      case (op)
        txq_pkg::H_PUSH: level <= level + 1'b1;
        txq_pkg::H_POP:  level <= level - 1'b1;
        default:         level <= level;
      endcase
      // A drop outranks a host clear in the same cycle.
      if (wr_en && full) ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end

  // R11: occupancy never exceeds the depth
  a_r11_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  // R11: a write into a full history raises the overflow flag
  a_r11_full_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> ovf);

  // R12: the flag holds until a clear
  a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  // R13: a read of an empty history returns nothing
  a_r13_no_vld_on_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_vld);

endmodule

// File: rtl/txq_pacer.sv
module txq_pacer #(
  parameter int DEPTH = 16,
  parameter int IV_W  = 16,
  parameter int ID_W  = 29,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fifo_en,
  input  logic                   fifo_empty,
  input  logic [IV_W-1:0]        gap_interval,
  input  logic                   gap_tick,
  input  logic                   tx_done,
  input  logic [ID_W-1:0]        tx_id,
  input  logic [TAG_W-1:0]       tx_tag,
  output logic                   req_next,
  input  logic                   hist_rd,
  input  logic                   hist_ovf_clr,
  output logic                   hist_vld,
  output logic [ID_W-1:0]        hist_id,
  output logic [TAG_W-1:0]       hist_tag,
  output logic [$clog2(DEPTH):0] hist_level,
  output logic                   hist_empty,
  output logic                   hist_ovf
);

  localparam int ENT_W = ID_W + TAG_W;

  logic [ENT_W-1:0] ent_wr;
  logic [ENT_W-1:0] ent_rd;

  assign ent_wr = {tx_tag, tx_id};

  txq_gap_timer #(.IV_W(IV_W)) gap_i (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .fifo_empty (fifo_empty),
    .interval   (gap_interval),
    .tick       (gap_tick),
    .tx_done    (tx_done),
    .req_q      (req_next)
  );

  txq_hist_fifo #(.DEPTH(DEPTH), .W(ENT_W)) hist_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tx_done),
    .wr_data (ent_wr),
    .rd_en   (hist_rd),
    .ovf_clr (hist_ovf_clr),
    .rd_vld  (hist_vld),
    .rd_data (ent_rd),
    .level   (hist_level),
    .empty   (hist_empty),
    .ovf     (hist_ovf)
  );

  assign hist_id  = ent_rd[ID_W-1:0];
  assign hist_tag = ent_rd[ENT_W-1:ID_W];

endmodule

// File: tb/txq_pacer_tb_top.sv
module txq_pacer_tb_top;

  localparam int DEPTH = 16;
  localparam int IV_W  = 16;
  localparam int ID_W  = 29;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst, fifo_en, fifo_empty, gap_tick, tx_done, hist_rd, hist_ovf_clr;
  logic [IV_W-1:0]  gap_interval;
  logic [ID_W-1:0]  tx_id;
  logic [TAG_W-1:0] tx_tag;
  logic req_next, hist_vld, hist_empty, hist_ovf;
  logic [ID_W-1:0]  hist_id;
  logic [TAG_W-1:0] hist_tag;
  logic [$clog2(DEPTH):0] hist_level;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  txq_pacer #(.DEPTH(DEPTH), .IV_W(IV_W), .ID_W(ID_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .fifo_empty(fifo_empty),
    .gap_interval(gap_interval), .gap_tick(gap_tick), .tx_done(tx_done),
    .tx_id(tx_id), .tx_tag(tx_tag), .req_next(req_next),
    .hist_rd(hist_rd), .hist_ovf_clr(hist_ovf_clr), .hist_vld(hist_vld),
    .hist_id(hist_id), .hist_tag(hist_tag), .hist_level(hist_level),
    .hist_empty(hist_empty), .hist_ovf(hist_ovf)
  );

  function automatic logic [ID_W-1:0] id_of(int i);
    return ID_W'(i * 97 + 5);
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(int i);
    return TAG_W'(i * 13 + 1);
  endfunction

  // Advance one clock; sample 1 ns after the edge.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; fifo_en = 0; fifo_empty = 1; gap_tick = 0; tx_done = 0;
    hist_rd = 0; hist_ovf_clr = 0; gap_interval = '0; tx_id = '0; tx_tag = '0;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic pulse_done(int i);
    tx_done = 1; tx_id = id_of(i); tx_tag = tag_of(i);
    cyc();
    tx_done = 0;
  endtask

  task automatic tick_once();
    gap_tick = 1;
    cyc();
    gap_tick = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 req", req_next, 0);
    chk("R1 vld", hist_vld, 0);
    chk("R1 empty", hist_empty, 1);
    chk("R1 level", hist_level, 0);
    chk("R1 ovf", hist_ovf, 0);

    // R2 / R3 / R9: sweep of gap lengths
    for (int n = 1; n <= 15; n++) begin
      do_reset();
      fifo_en = 1; fifo_empty = 0; gap_interval = IV_W'(n);
      cyc();
      chk("R2 first grant", req_next, 1);
      pulse_done(n);
      chk("R3 drop after done", req_next, 0);
      for (int k = 1; k <= n; k++) begin
        cyc(); cyc();
        chk("R3 idle cycles hold", req_next, 0);
        tick_once();
        chk("R3 grant at tick count", req_next, (k == n) ? 1 : 0);
      end
    end

    // R4: empty during gap, refill before expiry
    do_reset();
    fifo_en = 1; fifo_empty = 0; gap_interval = 16'd5;
    cyc();
    pulse_done(0);
    fifo_empty = 1;
    tick_once(); tick_once();
    fifo_empty = 0;
    cyc();
    chk("R4 refill waits", req_next, 0);
    tick_once(); tick_once();
    chk("R4 still waiting", req_next, 0);
    tick_once();
    chk("R4 grant at fifth tick", req_next, 1);

    // R5: gap expires while empty, refill much later
    for (int w = 0; w < 4; w++) begin
      do_reset();
      fifo_en = 1; fifo_empty = 0; gap_interval = 16'd3;
      cyc();
      pulse_done(0);
      fifo_empty = 1;
      for (int k = 0; k < 3 + w; k++) tick_once();
      chk("R5 no grant while empty", req_next, 0);
      for (int k = 0; k < w * 3; k++) cyc();
      fifo_empty = 0;
      cyc();
      chk("R5 immediate grant", req_next, 1);
    end

    // R6: zero gap, back to back
    do_reset();
    fifo_en = 1; fifo_empty = 0; gap_interval = '0;
    cyc();
    for (int i = 0; i < 6; i++) begin
      pulse_done(i);
      chk("R6 back to back", req_next, 1);
    end

    // R7: disable clears gap
    do_reset();
    fifo_en = 1; fifo_empty = 0; gap_interval = 16'd8;
    cyc();
    pulse_done(0);
    tick_once(); tick_once();
    fifo_en = 0;
    cyc();
    chk("R7 disabled drop", req_next, 0);
    fifo_en = 1;
    cyc();
    chk("R7 re-enable grants", req_next, 1);

    // R8: not ready cases
    fifo_empty = 1;
    cyc();
    chk("R8 empty no grant", req_next, 0);
    fifo_en = 0; fifo_empty = 0;
    cyc();
    chk("R8 disabled no grant", req_next, 0);

    // R13: read of empty history
    do_reset();
    hist_rd = 1;
    cyc();
    hist_rd = 0;
    chk("R13 no vld", hist_vld, 0);
    chk("R13 level", hist_level, 0);

    // R9 / R10: store with queue disabled, then drain in order
    for (int i = 0; i < 5; i++) pulse_done(i);
    chk("R9 level", hist_level, 5);
    chk("R9 not empty", hist_empty, 0);
    for (int i = 0; i < 5; i++) begin
      hist_rd = 1;
      cyc();
      hist_rd = 0;
      chk("R10 vld", hist_vld, 1);
      chk("R10 id", hist_id, id_of(i));
      chk("R10 tag", hist_tag, tag_of(i));
    end
    chk("R10 drained", hist_empty, 1);

    // R11 / R12: overflow
    do_reset();
    for (int i = 0; i < DEPTH; i++) pulse_done(i + 40);
    chk("R11 full level", hist_level, DEPTH);
    chk("R11 no ovf yet", hist_ovf, 0);
    for (int i = 0; i < 4; i++) pulse_done(i + 200);
    chk("R11 level capped", hist_level, DEPTH);
    chk("R11 ovf set", hist_ovf, 1);
    hist_ovf_clr = 1; tx_done = 1; tx_id = id_of(300); tx_tag = tag_of(300);
    cyc();
    hist_ovf_clr = 0; tx_done = 0;
    chk("R12 drop wins over clear", hist_ovf, 1);
    cyc();
    chk("R12 sticky", hist_ovf, 1);
    hist_ovf_clr = 1;
    cyc();
    hist_ovf_clr = 0;
    chk("R12 cleared", hist_ovf, 0);
    for (int i = 0; i < DEPTH; i++) begin
      hist_rd = 1;
      cyc();
      hist_rd = 0;
      chk("R11 kept id", hist_id, id_of(i + 40));
      chk("R11 kept tag", hist_tag, tag_of(i + 40));
    end
    chk("R11 drained", hist_level, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule